// File: doc/BRIEF.md
# Flash Protection Window Guard

This block decides, for every program or erase command aimed at a flash array, whether the command may proceed. An 8-bit protection register defines two address windows. The upper window always ends at the highest flash address. The lower window always starts at a fixed base. Each window has its own enable and its own size code. A global polarity bit sets the meaning of the windows. When the bit is 1, the enabled windows are locked islands and the rest of the flash is writable. When the bit is 0, the enabled windows are the only writable islands.

After reset the register is filled from a nonvolatile configuration byte, so the protection stored in the array takes effect at start-up. After that, software writes the register over a simple write strobe. Each size field can be changed only while its own window is disabled, and the reserved bit cannot be changed. The command sequencer presents an address and a command type. It gets back a combinational allow or deny in the same cycle. A refused command raises a sticky violation flag, and software clears that flag by writing a one.

Top module: `flash_prot_guard`

## Requirements
- R1: In the first clock edge after reset release, the register loads `nv_cfg`. Until that edge, every request is denied and the violation flag stays 0.
- R2: Register bit 6 is reserved. It keeps the value loaded at reset, and bus writes do not change it.
- R3: The upper-window size field (bits 4:3) takes a written value only when the upper-window disable bit (bit 5) already holds 1 before the write. Otherwise the field keeps its value.
- R4: The lower-window size field (bits 1:0) takes a written value only when the lower-window disable bit (bit 2) already holds 1 before the write. Otherwise the field keeps its value.
- R5: With polarity bit 7 = 1, an address inside an enabled window is denied and any other address is allowed. The window sizes are 2/4/8/16 KB for codes 0..3. The upper window ends at 0x7F_FFFF and the lower window starts at 0x7F_8000.
- R6: With bit 7 = 0, only addresses inside an enabled window are allowed.
- R7: A window whose disable bit is 1 has no effect on any decision.
- R8: A mass erase (type 2) is denied if any address in the block (0x7C_0000 to 0x7F_FFFF) is protected. A sector erase (type 1) is denied if any byte of its 1 KB sector is protected. A program (type 0) checks only its own address.
- R9: A denied request sets the violation flag on the next edge. A `viol_clr` pulse clears a set flag on the next edge.
- R10: While the flag is set, every request is denied and the flag stays set until it is cleared.
- R11: When `cmd_valid` is 0, or the type is 3, neither `cmd_allow` nor `cmd_deny` is raised and the flag does not change.
- R12: For every valid request, exactly one of `cmd_allow` and `cmd_deny` is 1, in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_cfg | input | 8 | Nonvolatile protection byte loaded after reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_q | output | 8 | Current protection register |
| viol_clr | input | 1 | Write-one-to-clear pulse for the violation flag |
| cmd_valid | input | 1 | Command present |
| cmd_type | input | 2 | 0 program, 1 sector erase, 2 mass erase, 3 none |
| cmd_addr | input | 23 | Global target address |
| cmd_allow | output | 1 | Command may proceed |
| cmd_deny | output | 1 | Command refused |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
The assertions run on every cycle. They check that the reserved bit and any locked size field stay frozen, that the flag is sticky and clears only on a write of one, that allow and deny never disagree, and that idle cycles raise neither answer. Only the bench scenarios can show that the window boundaries fall on the right addresses for each size code and polarity. The same holds for the mass-erase coverage result, for sector-extent checking, and for the exact value loaded from the configuration byte.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef enum logic [1:0] {
    CMD_PROG = 2'd0,
    CMD_SECT = 2'd1,
    CMD_MASS = 2'd2,
    CMD_NONE = 2'd3
  } fpg_cmd_e;

  // Packed MSB first: field positions match the register layout.
  typedef struct packed {
    logic       open_sel;   // bit 7: 1 = windows are locked islands
    logic       rsvd;       // bit 6: read-only
    logic       hi_dis;     // bit 5
    logic [1:0] hi_size;    // bits 4:3
    logic       lo_dis;     // bit 2
    logic [1:0] lo_size;    // bits 1:0
  } fpg_prot_t;

endpackage

// File: rtl/fpg_reg.sv
module fpg_reg
  import fpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] nv_cfg,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       loaded_o,
  output fpg_prot_t  prot_o
);

  fpg_prot_t prot_q, prot_d, wr_v;
  logic      loaded_q, loaded_d;
  logic      prot_en;

  assign wr_v = fpg_prot_t'(wr_data);

  always_comb begin
    loaded_d = 1'b1;
    prot_en  = !loaded_q || wr_en;
    prot_d   = prot_q;
    if (!loaded_q) begin
      prot_d = fpg_prot_t'(nv_cfg);
    end else if (wr_en) begin
      prot_d.open_sel = wr_v.open_sel;
      prot_d.hi_dis   = wr_v.hi_dis;
      prot_d.lo_dis   = wr_v.lo_dis;
      // size fields are gated by the disable bit held before the write
      if (prot_q.hi_dis) prot_d.hi_size = wr_v.hi_size;
      if (prot_q.lo_dis) prot_d.lo_size = wr_v.lo_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
    end else if (prot_en) begin
      prot_q <= prot_d;
    end
  end

  assign loaded_o = loaded_q;
  assign prot_o   = prot_q;

  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(prot_q.rsvd)); // R2
  AST_HI_SIZE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !prot_q.hi_dis) |=> $stable(prot_q.hi_size)); // R3
  AST_LO_SIZE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !prot_q.lo_dis) |=> $stable(prot_q.lo_size)); // R4

endmodule

// File: rtl/fpg_window.sv
module fpg_window #(
  parameter int              ADDR_W       = 23,
  parameter int              SIZE_W       = 2,
  parameter int              MIN_LOG2     = 11,
  parameter bit              TOP_ANCHORED = 1'b1,
  parameter logic [ADDR_W-1:0] ANCHOR     = '1
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o
);

  logic [ADDR_W-1:0] span;

  always_comb begin
    span = ADDR_W'(1) << (MIN_LOG2 + int'(size_i));
  end

  generate
    if (TOP_ANCHORED) begin : g_top
      assign last_o  = ANCHOR;
      assign first_o = ANCHOR - span + ADDR_W'(1);
    end else begin : g_base
      assign first_o = ANCHOR;
      assign last_o  = ANCHOR + span - ADDR_W'(1);
    end
  endgenerate

endmodule

// File: rtl/fpg_viol.sv
module fpg_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = flag_q ? !clr_i : set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !flag_q) |=> flag_q); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i) |=> !flag_q); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R10

endmodule

// File: rtl/flash_prot_guard.sv
module flash_prot_guard
  import fpg_pkg::*;
#(
  parameter int                ADDR_W    = 23,
  parameter int                MIN_LOG2  = 11,
  parameter int                SECT_LOG2 = 10,
  parameter logic [ADDR_W-1:0] TOP_ADDR  = 23'h7F_FFFF,
  parameter logic [ADDR_W-1:0] LO_BASE   = 23'h7F_8000,
  parameter logic [ADDR_W-1:0] BLK_BASE  = 23'h7C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        nv_cfg,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        prot_q,
  input  logic              viol_clr,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_allow,
  output logic              cmd_deny,
  output logic              viol_flag
);

  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_LOG2) - 1);

  fpg_prot_t         prot;
  logic              loaded;
  logic [ADDR_W-1:0] hi_first, hi_last, lo_first, lo_last;
  logic              hi_en, lo_en;
  logic [ADDR_W-1:0] probe_a, probe_b;
  logic              prot_a, prot_b, covered, any_prot, target_prot;
  logic              req_active, req_live, flag, set_viol;
  fpg_cmd_e          ctype;

  fpg_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .nv_cfg   (nv_cfg),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .loaded_o (loaded),
    .prot_o   (prot)
  );

  fpg_window #(
    .ADDR_W(ADDR_W), .SIZE_W(2), .MIN_LOG2(MIN_LOG2),
    .TOP_ANCHORED(1'b1), .ANCHOR(TOP_ADDR)
  ) u_hi_win (
    .size_i  (prot.hi_size),
    .first_o (hi_first),
    .last_o  (hi_last)
  );

  fpg_window #(
    .ADDR_W(ADDR_W), .SIZE_W(2), .MIN_LOG2(MIN_LOG2),
    .TOP_ANCHORED(1'b0), .ANCHOR(LO_BASE)
  ) u_lo_win (
    .size_i  (prot.lo_size),
    .first_o (lo_first),
    .last_o  (lo_last)
  );

  function automatic logic addr_locked(input logic [ADDR_W-1:0] a,
                                       input logic open_sel,
                                       input logic he, input logic le,
                                       input logic [ADDR_W-1:0] hf,
                                       input logic [ADDR_W-1:0] hl,
                                       input logic [ADDR_W-1:0] lf,
                                       input logic [ADDR_W-1:0] ll);
    logic in_any;
    in_any = (he && a >= hf && a <= hl) || (le && a >= lf && a <= ll);
    return open_sel ? in_any : !in_any;
  endfunction

  always_comb begin
    ctype   = fpg_cmd_e'(cmd_type);
    hi_en   = !prot.hi_dis;
    lo_en   = !prot.lo_dis;
    probe_a = (ctype == CMD_SECT) ? (cmd_addr & ~SECT_MASK) : cmd_addr;
    probe_b = (ctype == CMD_SECT) ? (cmd_addr |  SECT_MASK) : cmd_addr;
    prot_a  = addr_locked(probe_a, prot.open_sel, hi_en, lo_en,
                          hi_first, hi_last, lo_first, lo_last);
    prot_b  = addr_locked(probe_b, prot.open_sel, hi_en, lo_en,
                          hi_first, hi_last, lo_first, lo_last);
  end

  // whole-block coverage by the enabled windows (closed polarity)
  always_comb begin
    logic lo_from_base;
    lo_from_base = lo_en && (lo_first <= BLK_BASE);
    covered = (hi_en && hi_first <= BLK_BASE)
           || (lo_from_base && lo_last == TOP_ADDR)
           || (lo_from_base && hi_en &&
               ({1'b0, lo_last} + 1'b1) >= {1'b0, hi_first});
    any_prot = prot.open_sel ? (hi_en || lo_en) : !covered;
  end

  always_comb begin
    target_prot = (ctype == CMD_MASS) ? any_prot : (prot_a || prot_b);
    req_active  = cmd_valid && (ctype != CMD_NONE);
    req_live    = req_active && loaded;
    cmd_allow   = req_live && !flag && !target_prot;
    cmd_deny    = req_active && !cmd_allow;
    set_viol    = req_live && !flag && target_prot;
  end

  fpg_viol u_viol (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_viol),
    .clr_i  (viol_clr),
    .flag_o (flag)
  );

  assign viol_flag = flag;
  assign prot_q    = prot;

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    req_active |-> (cmd_allow ^ cmd_deny)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_active |-> (!cmd_allow && !cmd_deny)); // R11
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_active && !viol_clr) |=> $stable(viol_flag)); // R11
  AST_FLAG_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |-> !cmd_allow); // R10
  AST_PRELOAD_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> (!viol_flag || $past(viol_flag))); // R1

endmodule

// File: tb/flash_prot_guard_test.sv
module flash_prot_guard_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  nv_cfg;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  prot_q;
  logic        viol_clr;
  logic        cmd_valid;
  logic [1:0]  cmd_type;
  logic [22:0] cmd_addr;
  logic        cmd_allow, cmd_deny, viol_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_prot_guard uut (
    .clk(clk), .rst_n(rst_n), .nv_cfg(nv_cfg), .wr_en(wr_en),
    .wr_data(wr_data), .prot_q(prot_q), .viol_clr(viol_clr),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
    .cmd_allow(cmd_allow), .cmd_deny(cmd_deny), .viol_flag(viol_flag)
  );

  // {register, type, address, expected allow}
  localparam int NV = 23;
  localparam logic [33:0] VEC [NV] = '{
    {8'h84, 2'd0, 23'h7FF800, 1'b0},  // R5 upper code 0 edge
    {8'h84, 2'd0, 23'h7FF7FF, 1'b1},  // R5
    {8'h9C, 2'd0, 23'h7FC000, 1'b0},  // R5 upper code 3
    {8'h9C, 2'd0, 23'h7FBFFF, 1'b1},  // R5 R7 lower disabled
    {8'hA2, 2'd0, 23'h7F9FFF, 1'b0},  // R5 lower code 2 end
    {8'hA2, 2'd0, 23'h7FA000, 1'b1},  // R5
    {8'hA2, 2'd0, 23'h7F7FFF, 1'b1},  // R5 below lower base
    {8'hA4, 2'd0, 23'h7FFFFF, 1'b1},  // R7 both disabled
    {8'hA4, 2'd2, 23'h7C0000, 1'b1},  // R8 mass, nothing locked
    {8'h84, 2'd2, 23'h7C0000, 1'b0},  // R8 mass, upper locked
    {8'h24, 2'd0, 23'h7F8000, 1'b0},  // R6 closed, no windows
    {8'h24, 2'd2, 23'h7C0000, 1'b0},  // R8
    {8'h0C, 2'd0, 23'h7FF000, 1'b1},  // R6 upper code 1 start
    {8'h0C, 2'd0, 23'h7FEFFF, 1'b0},  // R6
    {8'h0C, 2'd1, 23'h7FF3FF, 1'b1},  // R8 sector inside
    {8'h0C, 2'd1, 23'h7FEC00, 1'b0},  // R8 sector outside
    {8'h21, 2'd0, 23'h7F8FFF, 1'b1},  // R6 lower code 1 end
    {8'h21, 2'd0, 23'h7F9000, 1'b0},  // R6
    {8'h21, 2'd2, 23'h7C0000, 1'b0},  // R8
    {8'h1B, 2'd0, 23'h7FA000, 1'b1},  // R6 both code 3
    {8'h1B, 2'd0, 23'h7FD000, 1'b1},  // R6
    {8'h1B, 2'd0, 23'h7F0000, 0},     // R6
    {8'h1B, 2'd2, 23'h7C0000, 1'b0}   // R8 block not covered
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] v);
    reg_write({v[7], 1'b0, 1'b1, 2'b00, 1'b1, 2'b00});
    reg_write({v[7], 1'b0, 1'b1, v[4:3], 1'b1, v[1:0]});
    reg_write(v);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] r, input logic [1:0] t);
    if (t != 2'd0) return "R8";
    return r[7] ? "R5" : "R6";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nv_cfg = 8'hC9; wr_en = 1'b0; wr_data = '0;
    viol_clr = 1'b0; cmd_valid = 1'b0; cmd_type = 2'd0; cmd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: release, request pending before the load edge
    rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_type = 2'd0; cmd_addr = 23'h7F0000;
    #1;
    check("R1 preload allow", cmd_allow, 0);
    check("R1 preload deny", cmd_deny, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 load value", prot_q, 8'hC9);
    check("R1 flag after load", viol_flag, 0);

    // R2 R3 R4: write rules (bit 6 loaded as 1)
    reg_write(8'h24);
    check("R3 R4 size locked", prot_q, 8'h6D);
    reg_write(8'hFF);
    check("R3 R4 size open", prot_q, 8'hFF);
    reg_write(8'h00);
    check("R2 reserved kept", prot_q, 8'h40);
    reg_write(8'h1B);
    check("R3 R4 locked again", prot_q, 8'h40);
    reg_write(8'h20);
    reg_write(8'h3B);
    check("R3 accept R4 refuse", prot_q, 8'h78);

    // table walk: R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  r;
      logic [1:0]  t;
      logic [22:0] a;
      logic        e;
      {r, t, a, e} = VEC[i];
      set_reg(r);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_type = t; cmd_addr = a;
      #1;
      check({tag_of(r, t), " allow"}, cmd_allow, e);
      check("R12 deny", cmd_deny, !e);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 flag", viol_flag, !e);
      clear_flag();
      check("R9 cleared", viol_flag, 0);
    end

    // R10: flag blocks an otherwise allowed request
    set_reg(8'h84);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = 2'd0; cmd_addr = 23'h7FF900;
    @(negedge clk);
    cmd_addr = 23'h7F0000;
    #1;
    check("R10 refuse allow", cmd_allow, 0);
    check("R10 refuse deny", cmd_deny, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 flag held", viol_flag, 1);
    clear_flag();
    cmd_valid = 1'b1;
    #1;
    check("R10 after clear", cmd_allow, 1);

    // R11: idle and type 3 do nothing
    cmd_type = 2'd3; cmd_addr = 23'h7FFFFF;
    #1;
    check("R11 type3 allow", cmd_allow, 0);
    check("R11 type3 deny", cmd_deny, 0);
    @(negedge clk);
    check("R11 type3 flag", viol_flag, 0);
    cmd_valid = 1'b0; cmd_type = 2'd0;
    #1;
    check("R11 idle deny", cmd_deny, 0);
    @(negedge clk);
    check("R11 idle flag", viol_flag, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule